// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the receive half of an I2C bus master. It assumes that the bus has already been claimed and that the slave address has been sent. Out of reset it waits with SCL pulled low. Software services it through a handful of controls:

- a data buffer read strobe;
- a three-bit word-length field;
- an acknowledge-enable bit;
- a receive-select bit;
- a stop request.

It reports back through a running flag, a one-cycle interrupt pulse and a busy flag. The bus pins are modelled as open-drain: each line has an output enable that pulls it low and a sampled input.

Each buffer read releases SCL and clocks in the next word, most significant bit first. If acknowledge is enabled, a further clock follows the word, during which the master holds SDA low. At the end of the word the interrupt fires, the running flag drops and SCL is held low again until the next read. The data returned by the first read is meaningless: that read only starts reception.

To finish a read, software clears acknowledge-enable before reading the second-to-last word. After the last word's interrupt it programs a one-bit transfer and reads again. During that bit SDA stays released, which the slave takes as the end of the transfer. Software then requests a stop. SCL half-period length is set by a divider input. A slave that holds SCL low stretches the high phase. Bus inputs are assumed to be already synchronous to the clock.

Top module: `i2c_rx_master`

## Requirements
- R1: After reset, scl_oe_o=1, sda_oe_o=0, run_o=0, irq_o=0 and busy_o=1.
- R2: A buf_rd_i pulse while held, with receive select set, raises run_o on the next cycle and releases SCL after one low half-period.
- R3: Length code 3'b000 gives 8 data clocks, code 3'b001 gives 1 data clock, and any other code k gives k data clocks.
- R4: SDA is sampled at the end of each SCL high phase, MSB first. rdata_o holds the received bits right-aligned with zeros above them, so 8 bits give the byte and k bits give byte>>(8-k).
- R5: With acknowledge enabled, exactly one extra SCL clock follows the data bits, and SDA is low at its rising edge.
- R6: With acknowledge disabled, no extra clock follows the data bits. The master never pulls SDA while SCL is high during data bits.
- R7: At the end of a transfer, irq_o pulses for one cycle, run_o falls, and SCL stays pulled low while no transfer runs.
- R8: Outside the stop sequence, sda_oe_o never changes while SCL is released.
- R9: A stop request while held pulls SDA low with SCL low, then releases SCL, then releases SDA while SCL is high. busy_o falls as SDA is released.
- R10: Buffer reads and stop requests during a running transfer, and reads after the stop, are ignored. The word completes with the programmed clock count, and after the stop both lines stay released.
- R11: With receive select cleared, a buffer read does not start a transfer: run_o stays 0 and SCL stays pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div_i | input | DIVW | SCL half-period in clock cycles (0 acts as 1) |
| cfg_wr_i | input | 1 | Loads the three configuration fields below |
| cfg_len_i | input | 3 | Word length code: 0 means 8 bits, k means k bits |
| cfg_ack_i | input | 1 | Acknowledge enable |
| cfg_rx_i | input | 1 | Receive select |
| buf_rd_i | input | 1 | Data buffer read strobe |
| rdata_o | output | 8 | Received data, right-aligned |
| stop_req_i | input | 1 | Request a stop condition |
| run_o | output | 1 | Transfer in progress (0 = interrupt pending) |
| irq_o | output | 1 | End-of-transfer pulse |
| busy_o | output | 1 | Bus owned, cleared after the stop |
| scl_oe_o | output | 1 | Pull SCL low |
| scl_i | input | 1 | Sampled SCL line |
| sda_oe_o | output | 1 | Pull SDA low |
| sda_i | input | 1 | Sampled SDA line |

## Verification
A behavioural slave drives word bits on SCL falling edges, counts clocks, and records SDA at the clock after the data bits.

- Short words with length codes 1 to 7 are mixed with full bytes. A counter that mishandled code 0 or decoded codes off by one would give a wrong clock count or misaligned data.
- Acknowledge is toggled word by word. A design that kept a ninth clock with acknowledge off, or let SDA float during that clock, is caught at the slave.
- Extra buffer reads, a stop request in mid-word, and a read with receive select cleared are injected. A design that restarted or stopped on them would show extra clocks or a lost interrupt.
- The closing one-bit transfer and the stop are checked edge by edge. Releasing SDA in the wrong order would never produce the stop pattern.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_LOW,
        ST_HIGH,
        ST_STOP_LO,
        ST_STOP_HI
    } rx_state_e;

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] left;
        logic             ack_en;
        logic             in_ack;
        logic             scl_oe;
        logic             sda_oe;
        logic             irq;
    } ctrl_t;

    typedef struct packed {
        logic [2:0] len;
        logic       ack;
        logic       rx;
    } cfg_t;

    // Length code 0 selects a full byte, any other code is a literal bit count.
    function automatic logic [CNT_W-1:0] word_bits(input logic [2:0] code);
        return (code == 3'd0) ? CNT_W'(BYTE_W) : CNT_W'(code);
    endfunction

endpackage

// File: rtl/i2c_rx_tick.sv
module i2c_rx_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [DIVW-1:0] div_i,
    output logic            tick_o
);

    localparam logic [DIVW-1:0] ONE = DIVW'(1);

    logic [DIVW-1:0] cnt_d, cnt_q;
    logic [DIVW-1:0] lim;

    always_comb begin
        lim    = (div_i == '0) ? '0 : div_i - ONE;
        tick_o = en_i && (cnt_q == lim);
        if (!en_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clr_i) begin
            sh_d = '0;
        end else if (shift_i) begin
            sh_d = {sh_q[W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign word_o = sh_q;

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
    import i2c_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             ack_i,
    input  logic             scl_in_i,
    output logic             tick_en_o,
    output logic             shift_o,
    output logic             clr_o,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             irq_o,
    output logic             run_o,
    output logic             busy_o
);

    ctrl_t q, d;

    always_comb begin
        d       = q;
        d.irq   = 1'b0;
        shift_o = 1'b0;
        clr_o   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
            end
            ST_HOLD: begin
                if (start_i) begin
                    d.st     = ST_LOW;
                    d.left   = len_i;
                    d.ack_en = ack_i;
                    d.in_ack = 1'b0;
                    clr_o    = 1'b1;
                end else if (stop_i) begin
                    d.st = ST_STOP_LO;
                end
            end
            ST_LOW: begin
                if (tick_i) d.st = ST_HIGH;
            end
            ST_HIGH: begin
                if (tick_i) begin
                    if (!q.in_ack) begin
                        shift_o = 1'b1;
                        d.left  = q.left - CNT_W'(1);
                    end
                    if (!q.in_ack && q.left != CNT_W'(1)) begin
                        d.st = ST_LOW;
                    end else if (!q.in_ack && q.ack_en) begin
                        d.in_ack = 1'b1;
                        d.st     = ST_LOW;
                    end else begin
                        d.st  = ST_HOLD;
                        d.irq = 1'b1;
                    end
                end
            end
            ST_STOP_LO: begin
                if (tick_i) d.st = ST_STOP_HI;
            end
            ST_STOP_HI: begin
                if (tick_i) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
        // Pin drivers are registered from the next state.
        d.scl_oe = (d.st == ST_HOLD) || (d.st == ST_LOW) || (d.st == ST_STOP_LO);
        d.sda_oe = (d.in_ack && ((d.st == ST_LOW) || (d.st == ST_HIGH)))
                 || (d.st == ST_STOP_LO) || (d.st == ST_STOP_HI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_HOLD;
            q.scl_oe <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // High phases only count while the line is actually high (stretching).
    assign tick_en_o = (q.st == ST_LOW) || (q.st == ST_STOP_LO)
                     || (((q.st == ST_HIGH) || (q.st == ST_STOP_HI)) && scl_in_i);
    assign scl_oe_o  = q.scl_oe;
    assign sda_oe_o  = q.sda_oe;
    assign irq_o     = q.irq;
    assign run_o     = (q.st == ST_LOW) || (q.st == ST_HIGH);
    assign busy_o    = (q.st != ST_IDLE);

    // R5
    ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HIGH) && q.in_ack |-> sda_oe_o);

endmodule

// File: rtl/i2c_rx_master.sv
module i2c_rx_master
    import i2c_rx_pkg::*;
#(
    parameter int DIVW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIVW-1:0]   half_div_i,
    input  logic              cfg_wr_i,
    input  logic [2:0]        cfg_len_i,
    input  logic              cfg_ack_i,
    input  logic              cfg_rx_i,
    input  logic              buf_rd_i,
    output logic [BYTE_W-1:0] rdata_o,
    input  logic              stop_req_i,
    output logic              run_o,
    output logic              irq_o,
    output logic              busy_o,
    output logic              scl_oe_o,
    input  logic              scl_i,
    output logic              sda_oe_o,
    input  logic              sda_i
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr_i) begin
            cfg_d.len = cfg_len_i;
            cfg_d.ack = cfg_ack_i;
            cfg_d.rx  = cfg_rx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic tick, tick_en, shift_en, shift_clr;

    i2c_rx_tick #(.DIVW(DIVW)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .div_i  (half_div_i),
        .tick_o (tick)
    );

    i2c_rx_shift #(.W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (shift_clr),
        .shift_i (shift_en),
        .bit_i   (sda_i),
        .word_o  (rdata_o)
    );

    i2c_rx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .start_i   (buf_rd_i && cfg_q.rx),
        .stop_i    (stop_req_i),
        .len_i     (word_bits(cfg_q.len)),
        .ack_i     (cfg_q.ack),
        .scl_in_i  (scl_i),
        .tick_en_o (tick_en),
        .shift_o   (shift_en),
        .clr_o     (shift_clr),
        .scl_oe_o  (scl_oe_o),
        .sda_oe_o  (sda_oe_o),
        .irq_o     (irq_o),
        .run_o     (run_o),
        .busy_o    (busy_o)
    );

    // R7
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !run_o && scl_oe_o);

    // R7
    hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !run_o && !sda_oe_o |-> scl_oe_o);

    // R8
    sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !scl_oe_o && !$past(scl_oe_o) |-> sda_oe_o == $past(sda_oe_o));

    // R10
    run_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> $past(buf_rd_i));

    // R9
    stop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !scl_oe_o && !sda_oe_o);

endmodule

// File: tb/tb_i2c_rx_master.sv
module tb_i2c_rx_master;

    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hdiv = 8'd2;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_len = 3'd0;
    logic       cfg_ack = 1'b0;
    logic       cfg_rx = 1'b0;
    logic       buf_rd = 1'b0;
    logic       stop_req = 1'b0;
    logic [7:0] rdata;
    logic       run, irq, busy, scl_oe, sda_oe;
    logic       scl_i, sda_i, slv_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // behavioural slave / monitor state
    logic [7:0] slv_byte = 8'h00;
    int         slv_n = 0;
    int         arm_tok = 0;
    int         seen_tok = 0;
    int         rises = 0;
    int         falls = 0;
    bit         ack_seen = 0;
    bit         ack_low = 0;
    bit         m_drive = 0;
    int         r8_viol = 0;
    logic       scl_prev = 1'b0;
    logic       oe_prev = 1'b0;

    always #10 clk = ~clk;

    assign scl_i  = !scl_oe;
    assign slv_oe = (falls < slv_n) && (slv_byte[3'(7 - falls)] == 1'b0);
    assign sda_i  = !(sda_oe || slv_oe);

    i2c_rx_master #(.DIVW(8)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_div_i (hdiv),
        .cfg_wr_i   (cfg_wr),
        .cfg_len_i  (cfg_len),
        .cfg_ack_i  (cfg_ack),
        .cfg_rx_i   (cfg_rx),
        .buf_rd_i   (buf_rd),
        .rdata_o    (rdata),
        .stop_req_i (stop_req),
        .run_o      (run),
        .irq_o      (irq),
        .busy_o     (busy),
        .scl_oe_o   (scl_oe),
        .scl_i      (scl_i),
        .sda_oe_o   (sda_oe),
        .sda_i      (sda_i)
    );

    always @(negedge clk) begin
        if (arm_tok != seen_tok) begin
            seen_tok = arm_tok;
            rises = 0; falls = 0; ack_seen = 0; ack_low = 0; m_drive = 0;
        end
        if (scl_i && !scl_prev) begin
            if (rises == slv_n) begin
                ack_seen = 1;
                ack_low  = !sda_i;
            end
            rises++;
        end
        if (!scl_i && scl_prev) falls++;
        if (scl_i && sda_oe && rises <= slv_n) m_drive = 1;
        if (scl_i && scl_prev && busy && sda_oe != oe_prev) r8_viol++;
        scl_prev = scl_i;
        oe_prev  = sda_oe;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
            $finish;
        end
    end

    function automatic int exp_len(input logic [2:0] code);
        return (code == 3'd0) ? 8 : int'(code);
    endfunction

    function automatic int exp_data(input logic [7:0] b, input logic [2:0] code);
        return int'(b >> (8 - exp_len(code)));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic [2:0] code, input bit ack, input bit rx);
        @(negedge clk);
        cfg_len = code; cfg_ack = ack; cfg_rx = rx; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_irq(output bit got);
        got = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (irq) begin
                got = 1;
                break;
            end
        end
    endtask

    // One word: program, arm slave, read, await interrupt, compare.
    task automatic run_word(input logic [2:0] code, input bit ack, input logic [7:0] b,
                            input bit disturb, input bit chk_data);
        bit got;
        int n;
        n = exp_len(code);
        setup(code, ack, 1'b1);
        slv_byte = b;
        slv_n    = n;
        arm_tok++;
        @(negedge clk);
        @(negedge clk);
        buf_rd = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0;
        chk(run == 1'b1, "R2 run after read", int'(run), 1);
        if (disturb) begin
            repeat (3) @(negedge clk);
            buf_rd = 1'b1; stop_req = 1'b1;
            @(negedge clk);
            buf_rd = 1'b0; stop_req = 1'b0;
        end
        wait_irq(got);
        chk(got, "R7 interrupt", int'(got), 1);
        chk(rises == n + int'(ack), disturb ? "R10 clocks with stray read/stop" : "R3 clock count",
            rises, n + int'(ack));
        if (ack) chk(ack_seen && ack_low, "R5 ack low", int'(ack_low), 1);
        else     chk(!ack_seen, "R6 no ack clock", int'(ack_seen), 0);
        chk(!m_drive, "R6 no master drive on data", int'(m_drive), 0);
        if (chk_data) chk(int'(rdata) == exp_data(b, code), "R4 data", int'(rdata), exp_data(b, code));
        chk(!run && scl_oe, "R7 held after word", int'({run, scl_oe}), 1);
        @(negedge clk);
        chk(!irq, "R7 single-cycle irq", int'(irq), 0);
        chk(busy, "R10 still busy", int'(busy), 1);
    endtask

    initial begin
        int phase;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(scl_oe && !sda_oe && !run && !irq && busy, "R1 reset state",
            int'({scl_oe, sda_oe, run, irq, busy}), 5'b10001);

        // First read only starts reception; data not compared.
        run_word(3'd0, 1'b1, 8'h5A, 1'b0, 1'b0);
        // directed corners
        hdiv = 8'd1; run_word(3'd0, 1'b1, 8'hA5, 1'b0, 1'b1);
        hdiv = 8'd3; run_word(3'd0, 1'b0, 8'h3C, 1'b0, 1'b1);
        hdiv = 8'd0; run_word(3'd1, 1'b0, 8'h80, 1'b0, 1'b1);
        hdiv = 8'd2; run_word(3'd3, 1'b1, 8'hA0, 1'b0, 1'b1);
        run_word(3'd7, 1'b0, 8'hFE, 1'b0, 1'b1);
        run_word(3'd0, 1'b1, 8'h00, 1'b0, 1'b1);
        run_word(3'd0, 1'b1, 8'hFF, 1'b0, 1'b1);

        // R10: stray read and stop request mid-word
        run_word(3'd0, 1'b1, 8'h96, 1'b1, 1'b1);

        // random words
        for (int k = 0; k < 24; k++) begin
            hdiv = 8'($urandom_range(1, 4));
            run_word(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                     8'($urandom_range(0, 255)), 1'b0, 1'b1);
        end

        // R11: receive select cleared
        setup(3'd0, 1'b1, 1'b0);
        arm_tok++;
        @(negedge clk);
        buf_rd = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0;
        repeat (20) @(negedge clk);
        chk(!run && scl_oe && rises == 0, "R11 read ignored without rx select",
            int'({run, scl_oe}), 1);

        // closing sequence: no-ack last byte, then 1-bit transfer
        hdiv = 8'd2;
        run_word(3'd0, 1'b0, 8'h71, 1'b0, 1'b1);
        run_word(3'd1, 1'b0, 8'h00, 1'b0, 1'b1);

        // R9: stop
        @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        phase = 0;
        for (int i = 0; i < 2000; i++) begin
            if (phase == 0 && !scl_i && !sda_i) phase = 1;
            else if (phase == 1 && scl_i && !sda_i) phase = 2;
            else if (phase == 2 && scl_i && sda_i) phase = 3;
            if (!busy) break;
            @(negedge clk);
        end
        chk(phase == 3, "R9 stop order", phase, 3);
        chk(!busy && !scl_oe && !sda_oe, "R9 lines released, not busy",
            int'({busy, scl_oe, sda_oe}), 0);

        // R10: read after stop ignored
        setup(3'd0, 1'b1, 1'b1);
        buf_rd = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0;
        repeat (10) @(negedge clk);
        chk(!run && !scl_oe && !sda_oe, "R10 read after stop ignored",
            int'({run, scl_oe, sda_oe}), 0);

        // R8
        chk(r8_viol == 0, "R8 SDA steady while SCL high", r8_viol, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule